// File: doc/BRIEF.md
# GPIO Interrupt Front End

This block turns a bank of asynchronous general-purpose input lines into a single interrupt request for a processor. Every line is brought into the clock domain through two flops. It is then judged either on its level or on a transition, according to its own type and polarity bits. The result is qualified by a per-line enable and becomes a raw status bit. A per-line mask then decides whether that status bit reaches the combined interrupt output.

Software drives the block through a small memory-mapped port with an address, write data, a write strobe and combinational read data. It programs the four configuration words and reads the status before and after masking. Latched transition events are retired by writing ones to an acknowledge word. A typical bring-up masks everything first. It then unmasks the wanted lines, picks rising-edge detection and enables only those lines, so that nothing glitches through during setup.

Top module: `gpio_irq_front`

## Requirements
- R1: After reset, every register reads zero (enable 0x30, mask 0x34, type 0x38, polarity 0x3C, masked status 0x40, raw status 0x44) and `irq_out` is low.
- R2: Words written to enable (0x30), mask (0x34), type (0x38) and polarity (0x3C) read back unchanged, with bit n belonging to line n.
- R3: A line whose enable bit is 0 never sets its raw status bit, whatever its input does.
- R4: With type bit 0 (edge mode), a rising input sets raw status bit n when polarity bit n is 1, and a falling input sets it when polarity bit n is 0. The bit reads as 1 three clock edges after the input changes.
- R5: A latched edge bit stays set after the input returns. Only writing 1 to bit n at address 0x4C clears it, and 0 bits in that write leave other lines untouched.
- R6: With type bit 1 (level mode), raw status bit n follows the active level (high when polarity is 1, low when it is 0) two edges after the input changes, without latching.
- R7: A mask bit of 1 removes its line from the masked status at 0x40 and from `irq_out`, while raw status at 0x44 still shows it.
- R8: `irq_out` is high exactly one clock edge after any masked status bit is set, and falls one edge after the masked status becomes zero.
- R9: After the bring-up sequence (mask all ones, then mask ~0x0D, type 0, polarity all ones, enable 0x0D), a rising edge on line 2 raises `irq_out`, and a rising edge on line 1 leaves the raw status and `irq_out` unchanged.
- R10: Disabling a line clears any edge it had latched, so it reads as 0 when the line is enabled again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_in | input | NUM_LINES | Asynchronous input lines |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_out | output | 1 | Combined registered interrupt request |

## Verification
Edge mode is tried with both directions of transition on lines of opposite polarity in the same run, which shows that each line picks its own edge. The same lines are then returned to their idle level, which separates latching from level following. Level mode uses one active-high and one active-low line, so a line that is active straight out of configuration is told apart from one that waits for its input. Separate patterns toggle a disabled line, a masked line and a line that has been disabled and enabled again, and each shows a different gate at work. The bring-up pattern toggles one line outside the enabled set and one inside it.

// File: rtl/gpio_irq_front.sv
module gpio_irq_front #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] gpio_in,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [31:0]          reg_wdata,
  input  logic                 reg_we,
  output logic [31:0]          reg_rdata,
  output logic                 irq_out
);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_TYPE = ADDR_W'(8'h38);
  localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(8'h3C);
  localparam logic [ADDR_W-1:0] A_MST  = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(8'h44);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(8'h4C);

  logic [NUM_LINES-1:0] en_q, mask_q, type_q, pol_q;
  logic [NUM_LINES-1:0] s1_q, s2_q, prev_q, lat_q;
  logic [NUM_LINES-1:0] act_lvl, hit, clr, raw, mst;
  logic [NUM_LINES-1:0] wfield;

  assign wfield = reg_wdata[NUM_LINES-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      type_q <= '0;
      pol_q  <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_EN:    en_q   <= wfield;
        A_MASK:  mask_q <= wfield;
        A_TYPE:  type_q <= wfield;
        A_POL:   pol_q  <= wfield;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= gpio_in;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign act_lvl = ~(s2_q ^ pol_q);
  assign hit     = ((pol_q & s2_q & ~prev_q) | (~pol_q & ~s2_q & prev_q)) & en_q & ~type_q;
  assign clr     = ((reg_we && reg_addr == A_ACK) ? wfield : '0) | ~en_q | type_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= (lat_q & ~clr) | hit;
  end

  assign raw = en_q & ((type_q & act_lvl) | (~type_q & lat_q));
  assign mst = raw & ~mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= |mst;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EN:    reg_rdata[NUM_LINES-1:0] = en_q;
      A_MASK:  reg_rdata[NUM_LINES-1:0] = mask_q;
      A_TYPE:  reg_rdata[NUM_LINES-1:0] = type_q;
      A_POL:   reg_rdata[NUM_LINES-1:0] = pol_q;
      A_MST:   reg_rdata[NUM_LINES-1:0] = mst;
      A_RAW:   reg_rdata[NUM_LINES-1:0] = raw;
      default: ;
    endcase
  end

  // R2
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && reg_addr == A_EN) |-> en_q == $past(wfield));

  // R4
  edge_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q & $past(hit)) == $past(hit));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~lat_q & $past(lat_q)) & ~$past(clr)) == '0);

  // R7
  masked_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> $past(|(raw & ~mask_q)));

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(reg_we && reg_addr == A_EN && wfield == '0) |-> reg_addr != A_RAW || reg_rdata == '0);
endmodule

// File: tb/sim_gpio_irq_front.sv
module sim_gpio_irq_front;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] gpio_in = '0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq_out;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_front #(.NUM_LINES(32), .ADDR_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata), .irq_out(irq_out));

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step(1);
    reg_we = 1'b0;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(string tag, logic [7:0] a, logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic quiesce();
    wr(8'h30, 32'h0);
    gpio_in = '0;
    step(4);
    wr(8'h34, 32'h0); wr(8'h38, 32'h0); wr(8'h3C, 32'h0);
    wr(8'h4C, 32'hFFFF_FFFF);
    step(1);
  endtask

  task automatic t_reset();
    rd("R1 enable", 8'h30, 0); rd("R1 mask", 8'h34, 0);
    rd("R1 type", 8'h38, 0);   rd("R1 polarity", 8'h3C, 0);
    rd("R1 masked", 8'h40, 0); rd("R1 raw", 8'h44, 0);
    chk("R1 irq", irq_out, 0);
  endtask

  task automatic t_cfg();
    wr(8'h30, 32'hA5A5_0F0F); wr(8'h34, 32'h1234_5678);
    wr(8'h38, 32'hFFFF_0000); wr(8'h3C, 32'h0000_FFFF);
    rd("R2 enable", 8'h30, 32'hA5A5_0F0F); rd("R2 mask", 8'h34, 32'h1234_5678);
    rd("R2 type", 8'h38, 32'hFFFF_0000);   rd("R2 polarity", 8'h3C, 32'h0000_FFFF);
    quiesce();
  endtask

  task automatic t_edge();
    wr(8'h3C, 32'h1); wr(8'h30, 32'h3);
    gpio_in[1:0] = 2'b11;
    step(2);
    rd("R4 not yet", 8'h44, 0);
    step(1);
    rd("R4 rising line0", 8'h44, 32'h1);
    chk("R8 irq lags", irq_out, 0);
    step(1);
    chk("R8 irq set", irq_out, 1);
    gpio_in[1:0] = 2'b00;
    step(3);
    rd("R4 falling line1", 8'h44, 32'h3);
  endtask

  task automatic t_ack();
    wr(8'h4C, 32'h2);
    rd("R5 partial ack", 8'h44, 32'h1);
    wr(8'h4C, 32'h0);
    rd("R5 zero ack", 8'h44, 32'h1);
    wr(8'h4C, 32'h1);
    rd("R5 full ack", 8'h44, 32'h0);
    chk("R8 irq still high", irq_out, 1);
    step(1);
    chk("R8 irq drops", irq_out, 0);
    quiesce();
  endtask

  task automatic t_level();
    wr(8'h38, 32'h30); wr(8'h3C, 32'h10); wr(8'h30, 32'h30);
    rd("R6 active low idle", 8'h44, 32'h20);
    gpio_in[5:4] = 2'b11;
    step(2);
    rd("R6 levels swap", 8'h44, 32'h10);
    gpio_in[4] = 1'b0;
    step(2);
    rd("R6 no latch", 8'h44, 32'h0);
  endtask

  task automatic t_mask();
    wr(8'h34, 32'h10);
    gpio_in[4] = 1'b1;
    step(3);
    rd("R7 raw shows", 8'h44, 32'h10);
    rd("R7 masked hides", 8'h40, 32'h0);
    chk("R7 irq blocked", irq_out, 0);
    wr(8'h34, 32'h0);
    rd("R7 unmasked", 8'h40, 32'h10);
    step(1);
    chk("R8 irq after unmask", irq_out, 1);
    quiesce();
  endtask

  task automatic t_disabled();
    wr(8'h3C, 32'h40);
    gpio_in[6] = 1'b1;
    step(4);
    rd("R3 disabled raw", 8'h44, 32'h0);
    chk("R3 disabled irq", irq_out, 0);
    gpio_in[6] = 1'b0;
    step(3);
    wr(8'h30, 32'h40);
    gpio_in[6] = 1'b1;
    step(3);
    rd("R10 latched", 8'h44, 32'h40);
    wr(8'h30, 32'h0); wr(8'h30, 32'h40);
    rd("R10 cleared", 8'h44, 32'h0);
    quiesce();
  endtask

  task automatic t_bringup();
    wr(8'h34, 32'hFFFF_FFFF); wr(8'h34, ~32'h0D);
    wr(8'h38, 32'h0); wr(8'h3C, 32'hFFFF_FFFF); wr(8'h30, 32'h0D);
    gpio_in[1] = 1'b1;
    step(4);
    rd("R9 line1 raw", 8'h44, 32'h0);
    chk("R9 line1 irq", irq_out, 0);
    gpio_in[2] = 1'b1;
    step(3);
    rd("R9 line2 masked", 8'h40, 32'h4);
    step(1);
    chk("R9 line2 irq", irq_out, 1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_cfg();
    t_edge();
    t_ack();
    t_level();
    t_mask();
    t_disabled();
    t_bringup();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule